// File: doc/BRIEF.md
# Programmable Resolution Time Tag Counter

This block keeps a 16-bit free-running time value that a bus protocol core uses to stamp its messages. A prescaler derives a one-microsecond base tick from the system clock. A second divider then advances the counter once every 2, 4, 8, 16, 32 or 64 microseconds, according to a 3-bit resolution code. Another code value steps the counter from an external oscillator pin instead. That pin is synchronised into the system clock domain, and the counter advances on each rising edge.

The host loads the counter directly and reads its value at any time. It can also issue two one-cycle commands: one clears the counter, and one advances it by exactly one count. The second command is a test aid that does not wait for the prescaler. When the protocol core pulses its start-of-message or end-of-message strobe, the block latches the counter into a matching stamp register and raises a one-cycle valid flag. When the counter wraps from its all-ones value to zero, the block emits a one-cycle rollover pulse for an interrupt controller.

Top module: `ttag_counter`

## Requirements
- R1: After reset, `count`, both stamp registers, both valid flags and `rollover` are all zero.
- R2: For resolution code k in 0..5 (000 = 2 µs up to 101 = 64 µs), the counter advances by one every CLKS_PER_US * 2^(k+1) clock cycles. The first advance comes exactly that many rising edges after the edge that sampled a clear command or a host write.
- R3: With code 110, each rising edge of `ext_clk` advances the counter once. The edge is seen three clock edges after the input changes. A level held high or a falling edge causes no further advance.
- R4: With code 111 (reserved), the counter never advances on its own.
- R5: A host write (`wr_en`) loads `wr_data` into the counter on the next edge and restarts the prescaler.
- R6: A clear command (`cmd_clear`) sets the counter to zero on the next edge and restarts the prescaler.
- R7: A step command (`cmd_step`) adds exactly one to the counter on the next edge, whatever the resolution code is, including 111.
- R8: An advance from FFFFh gives 0000h and makes `rollover` high for exactly that one cycle. Loads and clears never raise `rollover`.
- R9: A pulse on `som` or `eom` latches the counter value seen at that edge into `som_stamp` or `eom_stamp`. The matching valid flag is high for one cycle, and the stamp holds until the next event.
- R10: The order of precedence is clear, then write, then advance. A step command that coincides with a prescaler or external advance adds only one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_code | input | 3 | Resolution select: 0..5 prescaled, 6 external, 7 reserved |
| ext_clk | input | 1 | External oscillator, asynchronous |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write value |
| cmd_clear | input | 1 | Clear command pulse |
| cmd_step | input | 1 | Test step command pulse |
| som | input | 1 | Start-of-message strobe from the protocol core |
| eom | input | 1 | End-of-message strobe from the protocol core |
| count | output | 16 | Current counter value, readable by the host |
| som_stamp | output | 16 | Value captured at the last start of message |
| som_valid | output | 1 | One-cycle flag for a new start-of-message stamp |
| eom_stamp | output | 16 | Value captured at the last end of message |
| eom_valid | output | 1 | One-cycle flag for a new end-of-message stamp |
| rollover | output | 1 | One-cycle pulse on wrap to zero |

## Verification
A wrong microsecond or resolution divider state shows up at `count` as an advance that is early or late. This appears within one resolution period of a clear, so the bench measures that edge exactly for all six codes. A stuck or mis-staged synchroniser shifts the external advance away from the third edge, or makes it repeat while the pin is held high. Faults in precedence or capture show on the very next edge, in `count`, the stamps or `rollover`.

// File: rtl/ttag_pkg.sv
package ttag_pkg;
   localparam int CODE_W   = 3;
   localparam int NUM_RES  = 6;
   localparam int DIV_W    = NUM_RES;
   localparam logic [CODE_W-1:0] CODE_EXT = 3'd6;
   localparam logic [CODE_W-1:0] CODE_OFF = 3'd7;

   // microseconds between advances minus one, for prescaled codes
   function automatic logic [DIV_W-1:0] div_limit(input logic [CODE_W-1:0] c);
      int span;
      span = 2 << c;
      return DIV_W'(span - 1);
   endfunction
endpackage

// File: rtl/ttag_ext_sync.sv
module ttag_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES:0] pipe;

   if (STAGES < 2) begin : g_bad_stages
      $error("ttag_ext_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pipe[i] <= 1'b0;
         else if (i == 0)
            pipe[i] <= async_in;
         else
            pipe[i] <= pipe[i-1];
      end
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/ttag_prescaler.sv
module ttag_prescaler
   import ttag_pkg::*;
#(
   parameter int CLKS_PER_US = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              step
);
   localparam int US_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
   localparam logic [US_W-1:0] US_LAST = US_W'(CLKS_PER_US - 1);

   logic [US_W-1:0]  us_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] lim;
   logic             us_tick;
   logic             prescaled;

   if (CLKS_PER_US < 1) begin : g_bad_rate
      $error("ttag_prescaler: CLKS_PER_US must be positive");
   end

   assign us_tick   = (us_cnt == US_LAST);
   assign prescaled = (code < CODE_W'(NUM_RES));
   assign lim       = prescaled ? div_limit(code) : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         us_cnt  <= '0;
         div_cnt <= '0;
      end else if (restart) begin
         us_cnt  <= '0;
         div_cnt <= '0;
      end else begin
         us_cnt <= us_tick ? '0 : us_cnt + 1'b1;
         if (us_tick)
            div_cnt <= (div_cnt >= lim) ? '0 : div_cnt + 1'b1;
      end
   end

   assign step = prescaled && us_tick && (div_cnt >= lim);
endmodule

// File: rtl/ttag_capture.sv
module ttag_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic [W-1:0] val,
   output logic [W-1:0] stamp,
   output logic         valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp <= '0;
         valid <= 1'b0;
      end else begin
         valid <= evt;
         if (evt)
            stamp <= val;
      end
   end
endmodule

// File: rtl/ttag_counter.sv
module ttag_counter
   import ttag_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CLKS_PER_US = 125,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       res_code,
   input  logic             ext_clk,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             cmd_clear,
   input  logic             cmd_step,
   input  logic             som,
   input  logic             eom,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] som_stamp,
   output logic             som_valid,
   output logic [CNT_W-1:0] eom_stamp,
   output logic             eom_valid,
   output logic             rollover
);
   logic pre_step;
   logic ext_rise;
   logic advance;
   logic restart;

   if (CNT_W < 2) begin : g_bad_width
      $error("ttag_counter: CNT_W must be at least 2");
   end

   assign restart = cmd_clear | wr_en;

   ttag_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .code    (res_code),
      .step    (pre_step)
   );

   ttag_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk),
      .rise     (ext_rise)
   );

   always_comb begin
      advance = cmd_step;
      if (res_code == CODE_EXT)
         advance = advance | ext_rise;
      else if (res_code != CODE_OFF)
         advance = advance | pre_step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         rollover <= 1'b0;
      end else begin
         rollover <= 1'b0;
         if (cmd_clear)
            count <= '0;
         else if (wr_en)
            count <= wr_data;
         else if (advance) begin
            count    <= count + 1'b1;
            rollover <= &count;
         end
      end
   end

   ttag_capture #(.W(CNT_W)) u_cap_som (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (som),
      .val   (count),
      .stamp (som_stamp),
      .valid (som_valid)
   );

   ttag_capture #(.W(CNT_W)) u_cap_eom (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (eom),
      .val   (count),
      .stamp (eom_stamp),
      .valid (eom_valid)
   );
endmodule

// File: rtl/ttag_chk.sv
module ttag_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   res_code,
   input logic         wr_en,
   input logic [W-1:0] wr_data,
   input logic         cmd_clear,
   input logic         cmd_step,
   input logic         som,
   input logic         eom,
   input logic [W-1:0] count,
   input logic [W-1:0] som_stamp,
   input logic         som_valid,
   input logic [W-1:0] eom_stamp,
   input logic         eom_valid,
   input logic         rollover
);
   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clear |=> (count == '0));

   // R5
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cmd_clear) |=> (count == $past(wr_data)));

   // R7
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_step && !cmd_clear && !wr_en) |=> (count == $past(count) + 1'b1));

   // R4
   reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_code == 3'd7 && !cmd_clear && !wr_en && !cmd_step) |=> $stable(count));

   // R8
   wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |-> (count == '0 && $past(count) == '1));

   // R9
   som_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      som |=> (som_valid && som_stamp == $past(count)));

   // R9
   eom_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eom |=> (eom_valid && eom_stamp == $past(count)));

   // R9
   som_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !som |=> (!som_valid && $stable(som_stamp)));
endmodule

bind ttag_counter ttag_chk #(.W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .res_code  (res_code),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .cmd_clear (cmd_clear),
   .cmd_step  (cmd_step),
   .som       (som),
   .eom       (eom),
   .count     (count),
   .som_stamp (som_stamp),
   .som_valid (som_valid),
   .eom_stamp (eom_stamp),
   .eom_valid (eom_valid),
   .rollover  (rollover)
);

// File: tb/sim_ttag_counter.sv
`timescale 1ns/1ps
module sim_ttag_counter;
   localparam int CPU = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  res_code = 3'd7;
   logic        ext_clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        cmd_clear = 1'b0;
   logic        cmd_step = 1'b0;
   logic        som = 1'b0;
   logic        eom = 1'b0;
   logic [15:0] count, som_stamp, eom_stamp;
   logic        som_valid, eom_valid, rollover;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ttag_counter #(.CLKS_PER_US(CPU)) u0 (
      .clk(clk), .rst_n(rst_n), .res_code(res_code), .ext_clk(ext_clk),
      .wr_en(wr_en), .wr_data(wr_data), .cmd_clear(cmd_clear), .cmd_step(cmd_step),
      .som(som), .eom(eom), .count(count), .som_stamp(som_stamp),
      .som_valid(som_valid), .eom_stamp(eom_stamp), .eom_valid(eom_valid),
      .rollover(rollover)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_clear();
      cmd_clear = 1'b1; tick(1); cmd_clear = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] v);
      wr_en = 1'b1; wr_data = v; tick(1); wr_en = 1'b0;
   endtask

   task automatic do_step();
      cmd_step = 1'b1; tick(1); cmd_step = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 count", count, 0);
      check("R1 stamps", {som_stamp, eom_stamp}, 0);
      check("R1 flags", {som_valid, eom_valid, rollover}, 0);
   endtask

   // R2 and R6: exact advance edge for each prescaled code
   task automatic t_resolution(input int k);
      int p;
      p = CPU * (2 << k);
      res_code = 3'(k);
      do_write(16'h0055);
      do_clear();
      check("R6 clear", count, 0);
      tick(p - 1);
      check("R2 before period", count, 0);
      tick(1);
      check("R2 at period", count, 1);
      tick(p - 1);
      check("R2 second period early", count, 1);
      tick(1);
      check("R2 second period", count, 2);
   endtask

   task automatic t_external();
      res_code = 3'd6;
      do_write(16'h0100);
      tick(4);
      ext_clk = 1'b1;
      tick(2);
      check("R3 before sync", count, 16'h0100);
      tick(1);
      check("R3 rise counted", count, 16'h0101);
      tick(20);
      check("R3 high level", count, 16'h0101);
      ext_clk = 1'b0;
      tick(10);
      check("R3 falling edge", count, 16'h0101);
      ext_clk = 1'b1; tick(1); ext_clk = 1'b0;
      tick(5);
      check("R3 short pulse", count, 16'h0102);
   endtask

   task automatic t_reserved();
      res_code = 3'd7;
      do_write(16'h0005);
      ext_clk = 1'b1;
      tick(400);
      ext_clk = 1'b0;
      check("R4 reserved hold", count, 16'h0005);
   endtask

   task automatic t_write();
      res_code = 3'd0;
      tick(3);
      do_write(16'hABCD);
      check("R5 load", count, 16'hABCD);
      tick(CPU * 2 - 1);
      check("R5 restart early", count, 16'hABCD);
      tick(1);
      check("R5 restart period", count, 16'hABCE);
   endtask

   task automatic t_step();
      res_code = 3'd7;
      do_write(16'h0010);
      do_step();
      check("R7 step reserved", count, 16'h0011);
      res_code = 3'd5;
      do_step();
      check("R7 step slow code", count, 16'h0012);
      tick(3);
      check("R7 no extra", count, 16'h0012);
   endtask

   task automatic t_wrap();
      res_code = 3'd7;
      do_write(16'hFFFE);
      check("R8 no pulse on load", rollover, 0);
      do_step();
      check("R8 to FFFF", {rollover, count}, {1'b0, 16'hFFFF});
      do_step();
      check("R8 wrap", {rollover, count}, {1'b1, 16'h0000});
      tick(1);
      check("R8 pulse ends", rollover, 0);
      do_write(16'hFFFF);
      do_clear();
      check("R8 clear no pulse", {rollover, count}, 0);
   endtask

   task automatic t_capture();
      res_code = 3'd7;
      do_write(16'h1234);
      som = 1'b1; cmd_step = 1'b1; tick(1); som = 1'b0; cmd_step = 1'b0;
      check("R9 som stamp", {som_valid, som_stamp}, {1'b1, 16'h1234});
      check("R9 count moved", count, 16'h1235);
      tick(1);
      check("R9 som valid one cycle", som_valid, 0);
      eom = 1'b1; tick(1); eom = 1'b0;
      check("R9 eom stamp", {eom_valid, eom_stamp}, {1'b1, 16'h1235});
      check("R9 som holds", som_stamp, 16'h1234);
      tick(1);
      check("R9 eom valid one cycle", eom_valid, 0);
   endtask

   task automatic t_priority();
      res_code = 3'd7;
      do_write(16'h0700);
      cmd_clear = 1'b1; wr_en = 1'b1; wr_data = 16'h0999; cmd_step = 1'b1;
      tick(1);
      cmd_clear = 1'b0;
      check("R10 clear wins", count, 0);
      tick(1);
      cmd_step = 1'b0; wr_en = 1'b0;
      check("R10 write over step", count, 16'h0999);
      res_code = 3'd0;
      do_clear();
      tick(CPU * 2 - 1);
      do_step();
      check("R10 step with prescale adds one", count, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      for (int k = 0; k < 6; k++) t_resolution(k);
      t_external();
      t_reserved();
      t_write();
      t_step();
      t_wrap();
      t_capture();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule